// File: doc/BRIEF.md
# Delay-Locked Loop Lock and Freeze Controller

This block brings up the delay-locked loop that places the data-strobe sampling point inside a memory PHY. On a start request it takes a snapshot of four tuning values: the DLL start point, the step increment, a coarse strobe phase shift and a fine offset. It presents all four to the DLL while the loop is still off. In the next cycle it switches the DLL on, and only one cycle after that does it raise the run bit. It then watches the DLL status flags until every one of them reads one at the same time.

What happens after lock depends on the mode captured at start.

- **Tracking mode:** the DLL stays on, so it keeps following process, voltage and temperature drift, and the controller reports ready.
- **Freeze mode (low-frequency use only):** the controller takes the upper eight bits of the 10-bit locked delay code as a fixed force value and drives it with the DLL still on and running. One cycle later it clears the DLL-on bit, so the fixed delay takes over, and only then reports ready.

A bounded wait window flags an error if lock never appears. The memory initialization sequencer waits for `ready_o` before it issues any command.

Top module: `dll_lock_ctrl`

## Requirements
- R1: After reset, `dll_en_o`, `dll_run_o`, `ready_o` and `err_o` are 0, and `force_o`, `start_pt_o`, `inc_o`, `shift_o` and `offset_o` are 0.
- R2: A `start_i` pulse taken while the controller is idle or finished leads, in the next cycle, to the load step. In the load step `start_pt_o`, `inc_o`, `shift_o` and `offset_o` carry the values on the configuration inputs at the start cycle, with `dll_en_o`=0 and `dll_run_o`=0. Later changes on the configuration inputs do not alter these outputs.
- R3: One cycle after the load step, `dll_en_o`=1 and `dll_run_o`=0. In the following cycle `dll_run_o`=1, so the run bit never rises before the DLL-on bit has been high for a cycle.
- R4: Lock is seen only in a wait cycle where all LOCK_BITS (3) bits of `lock_flags_i` are 1. Any pattern with a zero bit keeps the controller waiting, with `dll_en_o`=1, `dll_run_o`=1 and `ready_o`=0.
- R5: In tracking mode (`freeze_i`=0 at start), the cycle after lock is seen shows `ready_o`=1, `dll_en_o`=1, `dll_run_o`=1 and `force_o`=0.
- R6: In freeze mode (`freeze_i`=1 at start), the cycle after lock is seen shows `force_o` = bits [9:2] of the `lock_code_i` sampled in the lock cycle, with `dll_en_o`=1, `dll_run_o`=1 and `ready_o`=0. One cycle later `dll_en_o`=0 and `ready_o`=1, and `force_o` holds that value whatever `lock_code_i` does afterwards.
- R7: If no lock is seen in the first TIMEOUT wait cycles, the cycle after the last of them shows `err_o`=1, `ready_o`=0, `dll_en_o`=0 and `dll_run_o`=0. A lock seen in the last window cycle is taken as success.
- R8: `start_i` has no effect while a bring-up is in progress (load, DLL-on, wait or force steps).
- R9: A `start_i` taken after ready or error clears `ready_o`, `err_o` and `force_o` and runs the sequence again from the load step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Bring-up request pulse |
| freeze_i | input | 1 | Mode at start: 1 = freeze to a fixed delay after lock |
| cfg_start_pt_i | input | START_W (8) | DLL start point |
| cfg_inc_i | input | INC_W (8) | DLL step increment |
| cfg_shift_i | input | SHIFT_W (3) | Coarse strobe phase shift |
| cfg_offset_i | input | OFFSET_W (7) | Fine strobe offset |
| lock_flags_i | input | LOCK_BITS (3) | DLL lock status bits |
| lock_code_i | input | CODE_W (10) | DLL locked delay code |
| start_pt_o | output | START_W | Start point driven to the DLL |
| inc_o | output | INC_W | Increment driven to the DLL |
| shift_o | output | SHIFT_W | Coarse shift driven to the DLL |
| offset_o | output | OFFSET_W | Fine offset driven to the DLL |
| dll_en_o | output | 1 | DLL-on bit |
| dll_run_o | output | 1 | DLL start bit |
| force_o | output | FORCE_W (8) | Forced delay value |
| ready_o | output | 1 | DLL usable; the sequencer may proceed |
| err_o | output | 1 | Lock wait timed out |

## Verification
Two events can land in the same cycle: lock appearing, and the wait window expiring. The bench provokes this by raising all lock bits in exactly the last window cycle, and expects success (ready, and no error). One cycle later it raises them too late, and expects the error. A restart request can also coincide with an active wait. The bench pulses `start_i` mid-wait and judges at the ports that the run bit stays high and the sequence ends with the original lock.

// File: rtl/dll_ctl_pkg.sv
package dll_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_DLLON  = 3'd2,
    ST_WAIT   = 3'd3,
    ST_FORCE  = 3'd4,
    ST_FROZEN = 3'd5,
    ST_LOCKED = 3'd6,
    ST_FAIL   = 3'd7
  } dll_state_t;
endpackage

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
  import dll_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       freeze_q_i,
  input  logic       lock_ok_i,
  input  logic       expired_i,
  output dll_state_t state_o,
  output logic       accept_o
);
  dll_state_t state_q, state_d;

  always_comb begin
    accept_o = start_i && (state_q == ST_IDLE || state_q == ST_LOCKED ||
                           state_q == ST_FROZEN || state_q == ST_FAIL);
    state_d = state_q;
    case (state_q)
      ST_LOAD:  state_d = ST_DLLON;
      ST_DLLON: state_d = ST_WAIT;
      ST_WAIT: begin
        if (lock_ok_i)      state_d = freeze_q_i ? ST_FORCE : ST_LOCKED;
        else if (expired_i) state_d = ST_FAIL;
      end
      ST_FORCE: state_d = ST_FROZEN;
      default:  if (accept_o) state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
  parameter int TIMEOUT = 64,
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (count_en_i) cnt_d = cnt_q + 1'b1;
    else            cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = count_en_i && (cnt_q == CNT_W'(TIMEOUT - 1));
endmodule

// File: rtl/dll_cfg_hold.sv
module dll_cfg_hold #(
  parameter int START_W  = 8,
  parameter int INC_W    = 8,
  parameter int SHIFT_W  = 3,
  parameter int OFFSET_W = 7,
  parameter int FORCE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_i,
  input  logic                freeze_i,
  input  logic [START_W-1:0]  start_pt_i,
  input  logic [INC_W-1:0]    inc_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  input  logic [OFFSET_W-1:0] offset_i,
  input  logic                grab_i,
  input  logic [FORCE_W-1:0]  force_src_i,
  output logic                freeze_q_o,
  output logic [START_W-1:0]  start_pt_o,
  output logic [INC_W-1:0]    inc_o,
  output logic [SHIFT_W-1:0]  shift_o,
  output logic [OFFSET_W-1:0] offset_o,
  output logic [FORCE_W-1:0]  force_o
);
  logic [FORCE_W-1:0] force_d;

  always_comb begin
    force_d = force_o;
    if (take_i)      force_d = '0;
    else if (grab_i) force_d = force_src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q_o <= 1'b0;
      start_pt_o <= '0;
      inc_o      <= '0;
      shift_o    <= '0;
      offset_o   <= '0;
    end else if (take_i) begin
      freeze_q_o <= freeze_i;
      start_pt_o <= start_pt_i;
      inc_o      <= inc_i;
      shift_o    <= shift_i;
      offset_o   <= offset_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_o <= '0;
    else        force_o <= force_d;
  end
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
  import dll_ctl_pkg::*;
#(
  parameter int START_W   = 8,
  parameter int INC_W     = 8,
  parameter int SHIFT_W   = 3,
  parameter int OFFSET_W  = 7,
  parameter int LOCK_BITS = 3,
  parameter int CODE_W    = 10,
  parameter int FORCE_W   = 8,
  parameter int TIMEOUT   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 freeze_i,
  input  logic [START_W-1:0]   cfg_start_pt_i,
  input  logic [INC_W-1:0]     cfg_inc_i,
  input  logic [SHIFT_W-1:0]   cfg_shift_i,
  input  logic [OFFSET_W-1:0]  cfg_offset_i,
  input  logic [LOCK_BITS-1:0] lock_flags_i,
  input  logic [CODE_W-1:0]    lock_code_i,
  output logic [START_W-1:0]   start_pt_o,
  output logic [INC_W-1:0]     inc_o,
  output logic [SHIFT_W-1:0]   shift_o,
  output logic [OFFSET_W-1:0]  offset_o,
  output logic                 dll_en_o,
  output logic                 dll_run_o,
  output logic [FORCE_W-1:0]   force_o,
  output logic                 ready_o,
  output logic                 err_o
);
  dll_state_t state;
  logic accept, freeze_q, lock_ok, expired, in_wait, grab;

  // Lock requires every status bit high in the same cycle.
  assign lock_ok = &lock_flags_i;
  assign in_wait = (state == ST_WAIT);
  assign grab    = in_wait && lock_ok && freeze_q;

  dll_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freeze_q_i(freeze_q),
    .lock_ok_i(lock_ok), .expired_i(expired), .state_o(state), .accept_o(accept)
  );

  dll_lock_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .count_en_i(in_wait), .expired_o(expired)
  );

  dll_cfg_hold #(
    .START_W(START_W), .INC_W(INC_W), .SHIFT_W(SHIFT_W),
    .OFFSET_W(OFFSET_W), .FORCE_W(FORCE_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .take_i(accept), .freeze_i(freeze_i),
    .start_pt_i(cfg_start_pt_i), .inc_i(cfg_inc_i), .shift_i(cfg_shift_i),
    .offset_i(cfg_offset_i), .grab_i(grab),
    .force_src_i(lock_code_i[CODE_W-1 -: FORCE_W]),
    .freeze_q_o(freeze_q), .start_pt_o(start_pt_o), .inc_o(inc_o),
    .shift_o(shift_o), .offset_o(offset_o), .force_o(force_o)
  );

  always_comb begin
    dll_en_o  = (state == ST_DLLON) || (state == ST_WAIT) ||
                (state == ST_FORCE) || (state == ST_LOCKED);
    dll_run_o = (state == ST_WAIT) || (state == ST_FORCE) ||
                (state == ST_FROZEN) || (state == ST_LOCKED);
    ready_o   = (state == ST_LOCKED) || (state == ST_FROZEN);
    err_o     = (state == ST_FAIL);
  end
endmodule

// File: rtl/dll_lock_ctrl_chk.sv
module dll_lock_ctrl_chk #(
  parameter int LOCK_BITS = 3,
  parameter int CODE_W    = 10,
  parameter int FORCE_W   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LOCK_BITS-1:0] lock_flags_i,
  input logic [CODE_W-1:0]    lock_code_i,
  input logic                 dll_en_o,
  input logic                 dll_run_o,
  input logic [FORCE_W-1:0]   force_o,
  input logic                 ready_o,
  input logic                 err_o
);
  assert_run_after_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_run_o) |-> $past(dll_en_o) && dll_en_o);

  assert_ready_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) && dll_en_o |-> $past(&lock_flags_i));

  assert_track_noforce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && dll_en_o |-> force_o == '0);

  assert_force_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|force_o) |-> {{(CODE_W-FORCE_W){1'b0}}, force_o} ==
                        $past(lock_code_i >> (CODE_W - FORCE_W)));

  assert_freeze_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_en_o) && dll_run_o |-> $stable(force_o) && ready_o);

  assert_err_nolock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !$past(&lock_flags_i));

  assert_ready_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && err_o));
endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk #(
  .LOCK_BITS(LOCK_BITS), .CODE_W(CODE_W), .FORCE_W(FORCE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_flags_i(lock_flags_i), .lock_code_i(lock_code_i),
  .dll_en_o(dll_en_o), .dll_run_o(dll_run_o), .force_o(force_o),
  .ready_o(ready_o), .err_o(err_o)
);

// File: tb/sim_dll_lock_ctrl.sv
module sim_dll_lock_ctrl;
  localparam int TIMEOUT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, freeze_i = 1'b0;
  logic [7:0] cfg_start_pt_i = '0, cfg_inc_i = '0;
  logic [2:0] cfg_shift_i = '0;
  logic [6:0] cfg_offset_i = '0;
  logic [2:0] lock_flags_i = '0;
  logic [9:0] lock_code_i = '0;
  logic [7:0] start_pt_o, inc_o, force_o;
  logic [2:0] shift_o;
  logic [6:0] offset_o;
  logic       dll_en_o, dll_run_o, ready_o, err_o;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dll_lock_ctrl #(.TIMEOUT(TIMEOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freeze_i(freeze_i),
    .cfg_start_pt_i(cfg_start_pt_i), .cfg_inc_i(cfg_inc_i),
    .cfg_shift_i(cfg_shift_i), .cfg_offset_i(cfg_offset_i),
    .lock_flags_i(lock_flags_i), .lock_code_i(lock_code_i),
    .start_pt_o(start_pt_o), .inc_o(inc_o), .shift_o(shift_o), .offset_o(offset_o),
    .dll_en_o(dll_en_o), .dll_run_o(dll_run_o), .force_o(force_o),
    .ready_o(ready_o), .err_o(err_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] partial_flags();
    logic [2:0] v;
    v = 3'($urandom());
    if (v == 3'b111) v = 3'b011;
    return v;
  endfunction

  function automatic logic [7:0] exp_force(logic [9:0] code);
    return code[9:2];
  endfunction

  // One bring-up. dly = wait cycle in which all lock bits first read 1.
  task automatic run_case(bit frz, int dly, logic [9:0] code, bit poke, logic [2:0] shf);
    logic [7:0] sp, ic;
    logic [6:0] of;
    sp = 8'($urandom()); ic = 8'($urandom()); of = 7'($urandom());
    @(negedge clk);
    start_i = 1'b1; freeze_i = frz; lock_flags_i = '0;
    cfg_start_pt_i = sp; cfg_inc_i = ic; cfg_shift_i = shf; cfg_offset_i = of;
    @(negedge clk);
    start_i = 1'b0; freeze_i = ~frz;
    cfg_start_pt_i = ~sp; cfg_inc_i = ~ic; cfg_shift_i = ~shf; cfg_offset_i = ~of;
    check("R2 start_pt", start_pt_o, sp);
    check("R2 inc", inc_o, ic);
    check("R2 shift", shift_o, shf);
    check("R2 offset", offset_o, of);
    check("R2 en/run low at load", {dll_en_o, dll_run_o}, 0);
    check("R9 ready/err/force cleared", {ready_o, err_o, force_o}, 0);
    @(negedge clk);
    check("R3 dll on before run", {dll_en_o, dll_run_o}, 2'b10);
    @(negedge clk);
    check("R3 run after dll on", {dll_en_o, dll_run_o}, 2'b11);
    for (int k = 0; k < TIMEOUT; k++) begin
      if (k >= dly) begin lock_flags_i = 3'b111; lock_code_i = code; end
      else begin lock_flags_i = partial_flags(); lock_code_i = 10'($urandom()); end
      if (poke && k == 1) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (k >= dly) break;
      if (k == TIMEOUT - 1) break;
      check(poke ? "R8 busy start ignored" : "R4 partial flags keep waiting",
            {dll_en_o, dll_run_o, ready_o, err_o}, 4'b1100);
    end
    if (dly < TIMEOUT) begin
      if (frz) begin
        check("R6 force value", force_o, exp_force(code));
        check("R6 en/run on, not ready", {dll_en_o, dll_run_o, ready_o}, 3'b110);
        lock_code_i = ~code; lock_flags_i = partial_flags();
        @(negedge clk);
        check("R6 dll off and ready", {dll_en_o, dll_run_o, ready_o, err_o}, 4'b0110);
        check("R6 force held", force_o, exp_force(code));
        @(negedge clk);
        check("R6 force stable after code change", force_o, exp_force(code));
      end else begin
        check("R5 tracking ready", {dll_en_o, dll_run_o, ready_o, err_o}, 4'b1110);
        check("R5 no force", force_o, 0);
      end
    end else begin
      check("R7 timeout error", {dll_en_o, dll_run_o, ready_o, err_o}, 4'b0001);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R1 reset outputs", {dll_en_o, dll_run_o, ready_o, err_o}, 0);
    check("R1 reset force", force_o, 0);
    check("R1 reset fields", {start_pt_o, inc_o, shift_o, offset_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {dll_en_o, dll_run_o, ready_o, err_o}, 0);
    // directed corners
    run_case(1'b0, 0, 10'h2A5, 1'b0, 3'd6);
    run_case(1'b1, 0, 10'h3FF, 1'b0, 3'd6);
    run_case(1'b1, TIMEOUT - 1, 10'h1B6, 1'b0, 3'd6);   // R7 lock in last cycle wins
    run_case(1'b0, TIMEOUT - 1, 10'h0C3, 1'b0, 3'd2);
    run_case(1'b0, TIMEOUT, 10'h155, 1'b0, 3'd1);       // R7 too late
    run_case(1'b1, TIMEOUT + 5, 10'h155, 1'b0, 3'd1);
    run_case(1'b1, 5, 10'h2F0, 1'b1, 3'd6);            // R8 start during wait
    run_case(1'b0, 7, 10'h001, 1'b1, 3'd3);
    // random mix
    for (int n = 0; n < 30; n++)
      run_case(1'($urandom()), int'($urandom_range(0, 50)),
               10'($urandom()), 1'($urandom()), 3'($urandom()));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule